// File: doc/BRIEF.md
# I/O Port Decoder and DAC Output Latch

This block sits on the bus of an 8-bit processor whose I/O space spans the full 16-bit address bus. All strobes are active low: I/O request, memory request, read and write. The block recognises an I/O write aimed at its write port. It then stores the data byte in an 8-bit register that feeds a single-channel 8-bit DAC. It also provides a read port that returns an 8-bit input value, for example joystick lines, during a matching I/O read. Every bus input is brought into the system clock domain through a two-flop synchroniser before any decision is made.

Write decoding is chosen at build time. A full compare uses all 16 address bits. A dual compare accepts either of two complete addresses. A partial compare examines only the bits selected by a mask. The default mask looks at one bit, so half of the I/O space aliases onto the port. A mask with two bits gives the quarter-space aliasing often used for banking ports.

The output register loads on the trailing edge of the decoded write select. It takes the byte that was sampled while the select was active, so the DAC never sees an intermediate value. The read path gives separate data and enable outputs; the tristate pad driver sits outside the block and is steered by the enable.

Top module: `io_port_dac_latch`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `dac_out` equals 0x80 and `data_oe` is 0.
- R2: An I/O write is `iorq_n`=0, `wr_n`=0 and `mreq_n`=1, with `data_in` and `addr` held for at least three clock edges. If its address matches the write decoder, `dac_out` takes that `data_in` value once the strobes have returned high and three rising clock edges have followed. While the write is still in progress, `dac_out` keeps its previous value.
- R3: `dac_out` does not change between matching writes, including during reads and during writes to non-matching addresses.
- R4: In partial mode (the default), only the address bits set in the mask are compared with the port value. With the default mask 0x0004 and port 0x00FB, any address with bit 2 equal to 0 (such as 0xABFB) is captured, and any address with bit 2 equal to 1 (such as 0x00FF or 0x7FFD) is ignored.
- R5: In full mode, only an exact 16-bit match is captured. With port 0x7FFD, 0x7FFD is captured, and 0x00FB and 0xABFB are ignored.
- R6: In dual mode, the exact addresses 0x00FB and 0x00DD are both captured. 0x00FD and 0xABFB are ignored.
- R7: A cycle with `mreq_n`=0 never triggers either port, even if the address matches.
- R8: During an I/O read (`iorq_n`=0, `rd_n`=0, `mreq_n`=1) to the read port (full compare, default 0x001F), `data_oe` goes to 1 and `data_out` equals `rd_src` by the third rising edge. `data_oe` returns to 0 in the same instant that `rd_n` or `iorq_n` rises.
- R9: `data_oe` stays 0, and `data_out` stays 0x00, during reads to other addresses such as 0x011F, and during writes to any address, the read port included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Processor address bus |
| iorq_n | input | 1 | I/O request strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| data_in | input | 8 | Data bus value seen by the block |
| rd_src | input | 8 | Value returned on a matching read |
| data_out | output | 8 | Read data toward the pad driver, 0 when not enabled |
| data_oe | output | 1 | Enable for the data bus pad driver |
| dac_out | output | 8 | Latched sample for the DAC |

## Verification
Four behaviours are checked by assertions on every clock cycle. The DAC register holds its reset value right after reset. It never moves unless a decoded write select was active in the preceding cycle. A memory-request cycle can never lead to a DAC update. The read enable only appears after a synchronised I/O read was seen. Which addresses alias in each decode mode, the exact data byte captured, the no-change-during-write behaviour, and the immediate drop of the read enable are shown only by the bench's directed bus cycles. These cycles run against three differently configured instances.

// File: rtl/io_port_pkg.sv
package io_port_pkg;

  typedef enum logic [1:0] {
    DEC_FULL    = 2'd0,
    DEC_DUAL    = 2'd1,
    DEC_PARTIAL = 2'd2
  } dec_mode_e;

endpackage

// File: rtl/io_bus_sync.sv
module io_bus_sync #(
  parameter int              W       = 8,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/io_addr_match.sv
module io_addr_match
  import io_port_pkg::*;
#(
  parameter int              AW   = 16,
  parameter dec_mode_e       MODE = DEC_FULL,
  parameter logic [AW-1:0]   PORT = '0,
  parameter logic [AW-1:0]   ALT  = '0,
  parameter logic [AW-1:0]   MASK = '1
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);

  generate
    case (MODE)
      DEC_FULL: begin : g_full
        assign hit = (addr == PORT);
      end
      DEC_DUAL: begin : g_dual
        assign hit = (addr == PORT) || (addr == ALT);
      end
      default: begin : g_partial
        assign hit = (((addr ^ PORT) & MASK) == '0);
      end
    endcase
  endgenerate

endmodule

// File: rtl/io_dac_reg.sv
module io_dac_reg #(
  parameter int            DW        = 8,
  parameter logic [DW-1:0] RST_LEVEL = 8'h80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic [DW-1:0] wdata,
  output logic          sel_q,
  output logic [DW-1:0] dac
);

  logic [DW-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      held  <= RST_LEVEL;
      dac   <= RST_LEVEL;
    end else begin
      sel_q <= sel;
      if (sel) held <= wdata;
      if (sel_q && !sel) dac <= held;
    end
  end

  AST_RESET_MIDSCALE: assert property (@(posedge clk)
    $past(rst) |-> dac == RST_LEVEL); // R1

  AST_HOLD_WITHOUT_SELECT: assert property (@(posedge clk) disable iff (rst)
    !sel_q |=> $stable(dac)); // R3

endmodule

// File: rtl/io_read_drv.sv
module io_read_drv #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit_s,
  input  logic [DW-1:0] src_s,
  input  logic          iorq_raw_n,
  input  logic          rd_raw_n,
  output logic          oe,
  output logic [DW-1:0] dout
);

  logic          armed;
  logic [DW-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      val_q <= '0;
    end else begin
      armed <= hit_s;
      val_q <= hit_s ? src_s : '0;
    end
  end

  assign oe   = armed & ~iorq_raw_n & ~rd_raw_n;
  assign dout = oe ? val_q : '0;

endmodule

// File: rtl/io_port_dac_latch.sv
module io_port_dac_latch
  import io_port_pkg::*;
#(
  parameter int              AW        = 16,
  parameter int              DW        = 8,
  parameter dec_mode_e       WR_MODE   = DEC_PARTIAL,
  parameter logic [AW-1:0]   WR_PORT   = 16'h00FB,
  parameter logic [AW-1:0]   WR_ALT    = 16'h00DD,
  parameter logic [AW-1:0]   WR_MASK   = 16'h0004,
  parameter dec_mode_e       RD_MODE   = DEC_FULL,
  parameter logic [AW-1:0]   RD_PORT   = 16'h001F,
  parameter logic [AW-1:0]   RD_MASK   = 16'hFFFF,
  parameter logic [DW-1:0]   RST_LEVEL = 8'h80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          iorq_n,
  input  logic          mreq_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] data_in,
  input  logic [DW-1:0] rd_src,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic [DW-1:0] dac_out
);

  localparam int SW = 4 + AW + 2 * DW;
  localparam logic [SW-1:0] SYNC_RST = {4'b1111, {(AW + 2 * DW){1'b0}}};

  logic [SW-1:0] bus_raw, bus_s;
  logic          mreq_s, iorq_s, rd_s, wr_s;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] wdata_s, src_s;
  logic          wr_hit, rd_hit;
  logic          wr_sel, rd_sel, wr_sel_q;

  assign bus_raw = {mreq_n, iorq_n, rd_n, wr_n, addr, data_in, rd_src};

  io_bus_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (bus_raw),
    .q   (bus_s)
  );

  assign {mreq_s, iorq_s, rd_s, wr_s, addr_s, wdata_s, src_s} = bus_s;

  io_addr_match #(.AW(AW), .MODE(WR_MODE), .PORT(WR_PORT), .ALT(WR_ALT),
                  .MASK(WR_MASK)) u_wr_match (
    .addr (addr_s),
    .hit  (wr_hit)
  );

  io_addr_match #(.AW(AW), .MODE(RD_MODE), .PORT(RD_PORT), .ALT(RD_PORT),
                  .MASK(RD_MASK)) u_rd_match (
    .addr (addr_s),
    .hit  (rd_hit)
  );

  assign wr_sel = wr_hit & ~iorq_s & ~wr_s & mreq_s;
  assign rd_sel = rd_hit & ~iorq_s & ~rd_s & mreq_s;

  io_dac_reg #(.DW(DW), .RST_LEVEL(RST_LEVEL)) u_dac (
    .clk   (clk),
    .rst   (rst),
    .sel   (wr_sel),
    .wdata (wdata_s),
    .sel_q (wr_sel_q),
    .dac   (dac_out)
  );

  io_read_drv #(.DW(DW)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .hit_s      (rd_sel),
    .src_s      (src_s),
    .iorq_raw_n (iorq_n),
    .rd_raw_n   (rd_n),
    .oe         (data_oe),
    .dout       (data_out)
  );

  AST_MREQ_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
    !mreq_s |=> ##1 $stable(dac_out)); // R7

  AST_OE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> $past(!iorq_s && !rd_s)); // R8

  AST_CAPTURE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_out) |-> $past(wr_sel_q)); // R2

endmodule

// File: tb/io_port_dac_latch_bench.sv
module io_port_dac_latch_bench;
  import io_port_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        iorq_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  data_in = '0, rd_src = '0;
  logic [7:0]  dout_p, dout_f, dout_d;
  logic        oe_p, oe_f, oe_d;
  logic [7:0]  dac_p, dac_f, dac_d;
  logic [7:0]  exp_p, exp_f, exp_d;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  io_port_dac_latch u_io_port_dac_latch (
    .clk(clk), .rst(rst), .addr(addr), .iorq_n(iorq_n), .mreq_n(mreq_n),
    .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in), .rd_src(rd_src),
    .data_out(dout_p), .data_oe(oe_p), .dac_out(dac_p));

  io_port_dac_latch #(.WR_MODE(DEC_FULL), .WR_PORT(16'h7FFD)) u_io_port_dac_latch_full (
    .clk(clk), .rst(rst), .addr(addr), .iorq_n(iorq_n), .mreq_n(mreq_n),
    .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in), .rd_src(rd_src),
    .data_out(dout_f), .data_oe(oe_f), .dac_out(dac_f));

  io_port_dac_latch #(.WR_MODE(DEC_DUAL)) u_io_port_dac_latch_dual (
    .clk(clk), .rst(rst), .addr(addr), .iorq_n(iorq_n), .mreq_n(mreq_n),
    .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in), .rd_src(rd_src),
    .data_out(dout_d), .data_oe(oe_d), .dac_out(dac_d));

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_dacs(string tag);
    check({tag, " partial"}, {8'h00, dac_p}, {8'h00, exp_p});
    check({tag, " full"},    {8'h00, dac_f}, {8'h00, exp_f});
    check({tag, " dual"},    {8'h00, dac_d}, {8'h00, exp_d});
  endtask

  task automatic bus_write(logic [15:0] a, logic [7:0] d, logic mreq,
                           bit hp, bit hf, bit hd, string tag);
    @(negedge clk);
    addr = a; data_in = d; mreq_n = mreq; iorq_n = 1'b0; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    check_dacs({tag, " unchanged mid-write R2"});
    check({tag, " no read enable during write R9"}, {15'h0, oe_p}, 16'h0);
    iorq_n = 1'b1; wr_n = 1'b1;
    repeat (6) @(negedge clk);
    mreq_n = 1'b1;
    if (hp) exp_p = d;
    if (hf) exp_f = d;
    if (hd) exp_d = d;
    check_dacs(tag);
  endtask

  task automatic bus_read(logic [15:0] a, logic [7:0] src, logic mreq,
                          bit hit, string tag);
    @(negedge clk);
    addr = a; rd_src = src; mreq_n = mreq; iorq_n = 1'b0; rd_n = 1'b0;
    repeat (5) @(negedge clk);
    check({tag, " enable"}, {15'h0, oe_p}, {15'h0, hit});
    check({tag, " data"}, {8'h00, dout_p}, hit ? {8'h00, src} : 16'h0);
    rd_n = 1'b1; iorq_n = 1'b1;
    #1;
    check({tag, " enable drops at release R8"}, {15'h0, oe_p}, 16'h0);
    check({tag, " data zero after release R9"}, {8'h00, dout_p}, 16'h0);
    repeat (5) @(negedge clk);
    mreq_n = 1'b1;
    check_dacs({tag, " hold across read R3"});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    exp_p = 8'h80; exp_f = 8'h80; exp_d = 8'h80;
    check_dacs("R1 in reset");
    check("R1 oe in reset", {15'h0, oe_p}, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    check_dacs("R1 after reset");
    check("R1 oe after reset", {15'h0, oe_p}, 16'h0);
  endtask

  task automatic t_decode();
    bus_write(16'h00FB, 8'h11, 1'b1, 1, 0, 1, "R4 R6 port FB");
    bus_write(16'hABFB, 8'h22, 1'b1, 1, 0, 0, "R4 alias ABFB, R5 R6 reject");
    bus_write(16'h00FF, 8'h33, 1'b1, 0, 0, 0, "R4 reject 00FF");
    bus_write(16'h7FFD, 8'h44, 1'b1, 0, 1, 0, "R5 exact 7FFD, R4 reject");
    bus_write(16'h00DD, 8'h55, 1'b1, 0, 0, 1, "R6 alternate DD");
    bus_write(16'h00FD, 8'h66, 1'b1, 0, 0, 0, "R6 reject FD R3");
    bus_write(16'h00FB, 8'hC3, 1'b1, 1, 0, 1, "R2 second capture");
  endtask

  task automatic t_mreq();
    bus_write(16'h00FB, 8'h77, 1'b0, 0, 0, 0, "R7 mreq blocks write");
    bus_write(16'h7FFD, 8'h78, 1'b0, 0, 0, 0, "R7 mreq blocks full");
    bus_read(16'h001F, 8'hA5, 1'b0, 0, "R7 mreq blocks read");
  endtask

  task automatic t_read();
    bus_read(16'h001F, 8'h5A, 1'b1, 1, "R8 matching read");
    bus_read(16'h001F, 8'hE1, 1'b1, 1, "R8 second value");
    bus_read(16'h011F, 8'h5A, 1'b1, 0, "R9 non-matching read");
    bus_write(16'h001F, 8'h99, 1'b1, 0, 0, 0, "R9 write to read port");
  endtask

  initial begin
    t_reset();
    t_decode();
    t_mreq();
    t_read();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule